// File: doc/BRIEF.md
# Decoder stream feeder

This block moves a byte stream from an upstream valid/ready source into the serial data input of an audio decoder. Each byte is shifted out one bit per clock, most significant bit first, with a strobe marking the first bit of each byte. The decoder throttles the feed through a data-request input. A burst begins only while that request is high. Once a burst is under way it may run on for a bounded number of bytes after the request falls.

A small player state machine sits on top of the serializer. It has four states: stopped, running, end-of-stream and empty. Three single-cycle command pulses drive it: start, stop and flush. A flush appends a programmable count of zero bytes after the real data so that the decoder drains its internal buffer. When the tail has gone out, the player reports empty. Only one command pulse is expected per cycle. If start or an accepted flush coincides with stop, stop loses.

Top module: `decoder_feeder`

## Requirements
- R1: Every byte occupies eight consecutive cycles with `sd_valid` high, bits in order from bit 7 down to bit 0 on `sd_bit`; `sd_sync` is high on the bit-7 cycle only.
- R2: A burst starts only while `dreq_i` is high, either on a start (or start-like flush) or on a low-to-high transition of `dreq_i`; a start given while `dreq_i` is low sends nothing until `dreq_i` rises.
- R3: Each burst opens with a window of WINDOW (32) bytes; every byte loaded while `dreq_i` is high resets the window so that it counts itself plus WINDOW-1 more; every byte loaded while `dreq_i` is low uses up one byte of the window; the burst ends when the window is empty.
- R4: When a byte slot comes up in the running state and `up_valid` is low, the state becomes end-of-stream.
- R5: A burst delivers at most BURST_MAX upstream bytes; the byte that reaches the limit moves the state to end-of-stream.
- R6: Stop moves running to stopped and is ignored in every other state; the byte already on the line finishes, and no further upstream byte is taken.
- R7: Flush is ignored when the state is empty and `up_valid` is low; otherwise it loads the zero counter with FLUSH_LEN only if that counter is zero, and when the state is not running it also acts as a start.
- R8: While the state is not running and the zero counter is nonzero, bytes of value 0x00 are sent under the R3 window rule; loading the last one sets the state to empty.
- R9: Start sets the state to running and, when `dreq_i` is high and no burst is active, begins a burst at once.
- R10: `play_state` encodes stopped=0, running=1, end-of-stream=2, empty=3; after reset it reads 0, and `up_ready` and `sd_valid` are low.
- R11: `up_ready` is high for exactly one cycle per upstream byte, only in the running state with `up_valid` high, and the byte on `up_data` in that cycle is the one serialized next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_data | input | 8 | Upstream byte |
| up_valid | input | 1 | Upstream byte available |
| up_ready | output | 1 | Upstream byte taken this cycle |
| go_i | input | 1 | Start command pulse |
| halt_i | input | 1 | Stop command pulse |
| drain_i | input | 1 | Flush command pulse |
| dreq_i | input | 1 | Decoder data request |
| sd_valid | output | 1 | Serial bit valid |
| sd_bit | output | 1 | Serial data bit |
| sd_sync | output | 1 | First-bit marker of each byte |
| play_state | output | 2 | Player state |

## Verification
The bench drops the data request right at the start of a burst and also after ten bytes. It then expects exactly 32 bytes in the first case and 40 in the second. A design that counts the window from byte completion, or that never resets it, gives a different total. A second flush issued during a partly sent zero tail must leave the count where it is. A design that reloads it sends a full FLUSH_LEN tail instead of the nine bytes that remain. The burst limit and a stop that lands on the fifth load are checked too. These catch an off-by-one at the limit and a design that takes one more upstream byte after stop.

// File: rtl/decoder_feeder.sv
module decoder_feeder #(
  parameter int WINDOW    = 32,
  parameter int BURST_MAX = 4096,
  parameter int FLUSH_LEN = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] up_data,
  input  logic       up_valid,
  output logic       up_ready,
  input  logic       go_i,
  input  logic       halt_i,
  input  logic       drain_i,
  input  logic       dreq_i,
  output logic       sd_valid,
  output logic       sd_bit,
  output logic       sd_sync,
  output logic [1:0] play_state
);

  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam int CNT_W = $clog2(BURST_MAX + 1);
  localparam int FL_W  = $clog2(FLUSH_LEN + 1);

  localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(WINDOW);
  localparam logic [WIN_W-1:0] WIN_HIGH = WIN_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_MAX - 1);
  localparam logic [FL_W-1:0]  FL_LOAD  = FL_W'(FLUSH_LEN);

  localparam logic [1:0] ST_STOP  = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_EOS   = 2'd2;
  localparam logic [1:0] ST_EMPTY = 2'd3;

  logic [1:0]       state, state_nxt;
  logic             busy, sending, dreq_q;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic [WIN_W-1:0] win;
  logic [CNT_W-1:0] bcnt;
  logic [FL_W-1:0]  fcnt;

  logic flush_ok, kick, burst_go, slot, win_ok;
  logic take_data, take_zero, starve, load;

  assign flush_ok  = drain_i && !(state == ST_EMPTY && !up_valid);
  assign kick      = go_i || (flush_ok && state != ST_RUN);
  assign burst_go  = !busy && dreq_i && ((dreq_i && !dreq_q) || kick);
  assign slot      = busy && (!sending || bit_idx == 3'd7);
  assign win_ok    = win != '0;
  assign take_data = slot && win_ok && state == ST_RUN && up_valid;
  assign starve    = slot && win_ok && state == ST_RUN && !up_valid;
  assign take_zero = slot && win_ok && state != ST_RUN && fcnt != '0;
  assign load      = take_data || take_zero;

  assign up_ready   = take_data;
  assign sd_valid   = sending;
  assign sd_bit     = shreg[7];
  assign sd_sync    = sending && bit_idx == 3'd0;
  assign play_state = state;

  always_comb begin
    state_nxt = state;
    if (starve || (take_data && bcnt == CNT_LAST)) state_nxt = ST_EOS;
    if (take_zero && fcnt == FL_W'(1))             state_nxt = ST_EMPTY;
    if (kick)                                      state_nxt = ST_RUN;
    else if (halt_i && state == ST_RUN)            state_nxt = ST_STOP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (load) begin
      sending <= 1'b1;
      bit_idx <= '0;
      shreg   <= take_data ? up_data : 8'h00;
    end else if (sending) begin
      shreg   <= {shreg[6:0], 1'b0};
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) sending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_STOP;
      busy   <= 1'b0;
      dreq_q <= 1'b0;
      win    <= '0;
      bcnt   <= '0;
      fcnt   <= '0;
    end else begin
      state  <= state_nxt;
      dreq_q <= dreq_i;
      if (burst_go)                    busy <= 1'b1;
      else if (slot && !load && !starve) busy <= 1'b0;
      if (burst_go)  win <= WIN_FULL;
      else if (load) win <= dreq_i ? WIN_HIGH : win - WIN_W'(1);
      if (burst_go)       bcnt <= '0;
      else if (take_data) bcnt <= bcnt + CNT_W'(1);
      if (flush_ok && fcnt == '0) fcnt <= FL_LOAD;
      else if (take_zero)         fcnt <= fcnt - FL_W'(1);
    end
  end

  AST_SYNC_THEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    sd_sync |=> (sd_valid && !sd_sync)); // R1
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready); // R11
  AST_READY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> (play_state == ST_RUN && up_valid)); // R11
  AST_STOP_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((play_state == ST_EOS || play_state == ST_EMPTY) && !go_i && !drain_i) |=> play_state != ST_STOP); // R6
  AST_NO_RUN_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (play_state == ST_RUN) |=> play_state != ST_EMPTY); // R8
  AST_NO_BITS_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_valid && !busy) |=> !sd_sync); // R2

endmodule

// File: tb/test_decoder_feeder.sv
module test_decoder_feeder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, halt = 1'b0, drain = 1'b0, dreq = 1'b0;
  logic up_ready, up_valid, sd_valid, sd_bit, sd_sync;
  logic [7:0] up_data;
  logic [1:0] pstate;

  logic [7:0] src_mem [0:511];
  int src_len = 0;
  int src_idx = 0;
  logic [7:0] rx_mem [0:1023];
  int rx_count = 0;
  int sync_err = 0;
  int rdy_count = 0;
  int nb = 0;
  logic [7:0] sh = 8'h00;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign up_valid = src_idx < src_len;
  assign up_data  = src_mem[src_idx[8:0]];

  always @(posedge clk) if (up_ready) src_idx <= src_idx + 1;

  always @(negedge clk) begin
    if (up_ready) rdy_count = rdy_count + 1;
    if (sd_valid) begin
      if (sd_sync != (nb == 0)) sync_err = sync_err + 1;
      sh = {sh[6:0], sd_bit};
      nb = nb + 1;
      if (nb == 8) begin
        rx_mem[rx_count[9:0]] = sh;
        rx_count = rx_count + 1;
        nb = 0;
      end
    end
  end

  decoder_feeder #(.WINDOW(32), .BURST_MAX(100), .FLUSH_LEN(40)) i_decoder_feeder (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
    .go_i(go), .halt_i(halt), .drain_i(drain), .dreq_i(dreq),
    .sd_valid(sd_valid), .sd_bit(sd_bit), .sd_sync(sd_sync), .play_state(pstate));

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int n, input int seed);
    for (int i = 0; i < n; i++) src_mem[(src_len + i) % 512] = 8'(seed + i * 7);
    src_len = src_len + n;
  endtask

  task automatic pulse_go();
    go = 1'b1; step(); go = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset state", pstate, 0);
    chk("R10 reset ready", up_ready, 0);
    chk("R10 reset serial", sd_valid, 0);
  endtask

  task automatic t_basic();
    int base = rx_count;
    int rb = rdy_count;
    load(1, 8'hA5); load(1, 8'h3C); load(1, 8'hFF); load(1, 8'h00); load(1, 8'h81);
    dreq = 1'b1;
    pulse_go();
    wait_n(70);
    chk("R9 start bursts", rx_count - base, 5);
    chk("R1 byte0", rx_mem[base], 8'hA5);
    chk("R1 byte1", rx_mem[base + 1], 8'h3C);
    chk("R1 byte4", rx_mem[base + 4], 8'h81);
    chk("R11 ready per byte", rdy_count - rb, 5);
    chk("R4 starve gives eos", pstate, 2);
    chk("R1 sync placement", sync_err, 0);
  endtask

  task automatic t_stop_ignored();
    halt = 1'b1; step(); halt = 1'b0;
    step();
    chk("R6 stop ignored in eos", pstate, 2);
  endtask

  task automatic t_dreq_low_start();
    int base;
    dreq = 1'b0; step();
    base = rx_count;
    load(10, 8'h10);
    pulse_go();
    wait_n(40);
    chk("R9 start sets running", pstate, 1);
    chk("R2 no burst with dreq low", rx_count - base, 0);
    halt = 1'b1; step(); halt = 1'b0;
    step();
    chk("R6 stop from running", pstate, 0);
    pulse_go();
    wait_n(10);
    chk("R2 still quiet", rx_count - base, 0);
    dreq = 1'b1;
    wait_n(120);
    chk("R2 rise starts burst", rx_count - base, 10);
    chk("R4 eos after data", pstate, 2);
  endtask

  task automatic t_window_first();
    int base = rx_count;
    load(60, 8'h20);
    go = 1'b1; step(); go = 1'b0; dreq = 1'b0;
    wait_n(600);
    chk("R3 window with no request", rx_count - base, 32);
    chk("R3 still running", pstate, 1);
    dreq = 1'b1;
    wait_n(300);
    chk("R3 rest after rise", rx_count - base, 60);
    chk("R4 eos", pstate, 2);
  endtask

  task automatic t_window_reload();
    int base = rx_count;
    int k = 0;
    load(60, 8'h30);
    go = 1'b1; step(); go = 1'b0;
    while (1) begin
      if (up_ready) k++;
      if (k == 10) break;
      step();
    end
    dreq = 1'b0;
    wait_n(600);
    chk("R3 window reloaded", rx_count - base, 40);
    dreq = 1'b1;
    wait_n(250);
    chk("R3 remainder", rx_count - base, 60);
  endtask

  task automatic t_burst_limit();
    int base = rx_count;
    load(150, 8'h05);
    pulse_go();
    wait_n(1000);
    chk("R5 burst limit count", rx_count - base, 100);
    chk("R5 limit gives eos", pstate, 2);
    chk("R5 last byte", rx_mem[base + 99], 8'(8'h05 + 99 * 7));
    pulse_go();
    wait_n(500);
    chk("R5 next burst", rx_count - base, 150);
  endtask

  task automatic t_stop_mid();
    int base = rx_count;
    int rb = rdy_count;
    int k = 0;
    load(60, 8'h50);
    go = 1'b1; step(); go = 1'b0;
    while (1) begin
      if (up_ready) k++;
      if (k == 5) break;
      step();
    end
    halt = 1'b1; step(); halt = 1'b0;
    wait_n(100);
    chk("R6 stop mid burst bytes", rx_count - base, 5);
    chk("R6 stop mid burst taken", rdy_count - rb, 5);
    chk("R6 stop state", pstate, 0);
    src_len = src_idx;
  endtask

  task automatic t_flush_basic();
    int base = rx_count;
    int nz = 0;
    drain = 1'b1; step(); drain = 1'b0;
    wait_n(450);
    chk("R8 zero tail length", rx_count - base, 40);
    for (int i = 0; i < 40; i++) if (rx_mem[(base + i) % 1024] != 8'h00) nz++;
    chk("R8 tail bytes zero", nz, 0);
    chk("R8 empty after tail", pstate, 3);
  endtask

  task automatic t_flush_ignored();
    int base = rx_count;
    drain = 1'b1; step(); drain = 1'b0;
    wait_n(60);
    chk("R7 flush ignored bytes", rx_count - base, 0);
    chk("R7 flush ignored state", pstate, 3);
  endtask

  task automatic t_flush_window();
    int base = rx_count;
    load(1, 8'h77);
    drain = 1'b1; step(); drain = 1'b0; dreq = 1'b0;
    wait_n(600);
    chk("R8 tail under window", rx_count - base, 32);
    chk("R7 flush sends data first", rx_mem[base % 1024], 8'h77);
    chk("R8 tail pending eos", pstate, 2);
    drain = 1'b1; step(); drain = 1'b0;
    wait_n(30);
    chk("R7 flush acts as start", pstate, 1);
    chk("R7 no burst while dreq low", rx_count - base, 32);
    dreq = 1'b1;
    wait_n(200);
    chk("R7 count not reloaded", rx_count - base, 41);
    chk("R8 empty at end", pstate, 3);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_stop_ignored();
    t_dreq_low_start();
    t_window_first();
    t_window_reload();
    t_burst_limit();
    t_stop_mid();
    t_flush_basic();
    t_flush_ignored();
    t_flush_window();
    chk("R1 sync placement overall", sync_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule